// File: doc/BRIEF.md
# Per-Stream Serial Input Skew Aligner

This block sits on one serial time-division input stream ahead of a time-slot interchange. It deserializes the stream into channel bytes, but it places its sampling window later than the frame boundary by a programmed amount. That amount is a whole number of channel times plus a number of quarter-bit steps. Streams that reach the chip with different skews can therefore each be given their own setting, so that all of them present channel 0 in line with the common frame.

The stream runs at one of four rates. These are 1/8, 1/4, 1/2 or all of the top rate, for example 2.048, 4.096, 8.192 or 16.384 Mb/s. The block runs on a fast sampling clock with `2^CLK_LOG2` cycles per bit at the top rate, so a frame always lasts `2^(CH_LOG2+3+CLK_LOG2)` cycles whatever the rate. A host writes the rate code, the channel delay and the quarter-bit delay. The block takes them in only at a frame pulse. Each completed byte comes out with its channel number as a one-cycle strobe.

Top module: `input_skew_aligner`

## Requirements
- R1: After reset `byte_valid` is low, and it stays low until the first `frame_pulse` has been seen.
- R2: With bit period B cycles and total delay D = ch·8·B + q·B/4 cycles (ch is the effective channel delay, q is `quarter_delay`), bit k (0..7) of channel c is sampled at clock edge frame_edge + D + c·8·B + k·B + B/2, taken modulo the frame length. `byte_valid` is high in the cycle after the edge at which bit 7 is sampled, and `byte_chan` = c.
- R3: The bits are received MSB first: the first bit of a channel lands in `byte_out[7]` and the last in `byte_out[0]`.
- R4: The effective channel delay is `chan_delay` modulo the channels per frame at the active rate, 2^(CH_LOG2-3+rate).
- R5: Rate code r (0..3) gives a bit period B = 2^(CLK_LOG2+3-r) cycles and 2^(CH_LOG2-3+r) channels per frame. Code 3 is the top rate.
- R6: `rate_sel`, `chan_delay` and `quarter_delay` are sampled only in a cycle with `frame_pulse` high. A change made in the middle of a frame has no effect until the next frame pulse.
- R7: When a frame pulse brings a changed setting, or arrives off the frame grid, the byte that straddles it is discarded. From then on every frame period delivers exactly one byte per channel.
- R8: `byte_valid` is never high in two consecutive cycles, and `byte_chan` is always below the channel count of the active rate.
- R9: A frame pulse restarts the frame position at zero. The frame position then advances by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | One-cycle frame boundary marker |
| ser_in | input | 1 | Serial stream data |
| rate_sel | input | 2 | Rate code: 0 = 1/8, 1 = 1/4, 2 = 1/2, 3 = full top rate |
| chan_delay | input | CHD_W | Delay in whole channel times |
| quarter_delay | input | BD_W | Additional delay in quarter-bit steps (0..31) |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_out | output | 8 | Received channel byte, first bit in bit 7 |
| byte_chan | output | CH_LOG2 | Channel number of `byte_out` |

## Verification
A frame pulse that loads a new setting can fall in the same cycle as a bit sample, or as the completion of a byte whose earlier bits were taken under the old setting. The bench provokes this by changing the setting half a frame before each pulse. It sweeps every rate, every channel delay including values past the wrap, and quarter delays up to 31, so that the last channel's window straddles the boundary. Each byte is judged on its sampling position, its channel and its data against the arithmetic model. Each full frame after a change must contain exactly one byte per channel.

// File: rtl/skew_align_pkg.sv
// Shared definitions for the input skew aligner.
// Assumes: a byte carries eight bits and a quarter-bit step is a
// quarter of one bit period.
package skew_align_pkg;
    typedef enum logic [1:0] {
        RATE_EIGHTH  = 2'd0,
        RATE_QUARTER = 2'd1,
        RATE_HALF    = 2'd2,
        RATE_FULL    = 2'd3
    } rate_t;

    localparam int BYTE_LOG2 = 3;
    localparam int QSTEP_LOG2 = 2;
endpackage

// File: rtl/skew_frame_timer.sv
// Frame position counter.
// Counts sampling-clock cycles from the latest frame pulse. The cycle in
// which the pulse is high is position zero. It flags a pulse that does not
// land on the expected frame grid.
// Assumes: the frame length is a power of two, so the count wraps by itself.
module skew_frame_timer #(
    parameter int FW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    output logic [FW-1:0] pos_now,
    output logic          run_now,
    output logic          run_seen,
    output logic          resync
);
    logic [FW-1:0] pos_q;

    // position of the current cycle within the frame
    always_comb begin
        pos_now = frame_pulse ? '0 : pos_q;
        run_now = frame_pulse | run_seen;
        resync  = frame_pulse && (pos_q != '0);
    end

    // advance the position and remember that a frame pulse has arrived
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            run_seen <= 1'b0;
        end else begin
            pos_q <= pos_now + FW'(1);
            if (frame_pulse) run_seen <= 1'b1;
        end
    end

    // R9
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (pos_q == FW'(1)));
endmodule

// File: rtl/skew_cfg_hold.sv
// Delay setting holder.
// Captures the rate code, channel delay and quarter delay at a frame pulse.
// In the pulse cycle it presents the incoming values, so that the new frame
// starts under the new setting. It flags when the captured setting changes.
// Assumes: the host holds its values steady around the frame pulse.
module skew_cfg_hold
    import skew_align_pkg::*;
#(
    parameter int CHD_W = 8,
    parameter int BD_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic [1:0]       rate_sel,
    input  logic [CHD_W-1:0] chan_delay,
    input  logic [BD_W-1:0]  quarter_delay,
    output rate_t            rate_now,
    output logic [CHD_W-1:0] cd_now,
    output logic [BD_W-1:0]  bd_now,
    output rate_t            rate_act,
    output logic             changed
);
    logic [CHD_W-1:0] cd_q;
    logic [BD_W-1:0]  bd_q;

    // pick the setting that governs the current cycle
    always_comb begin
        rate_now = frame_pulse ? rate_t'(rate_sel) : rate_act;
        cd_now   = frame_pulse ? chan_delay : cd_q;
        bd_now   = frame_pulse ? quarter_delay : bd_q;
        changed  = frame_pulse && ((rate_t'(rate_sel) != rate_act) ||
                   (chan_delay != cd_q) || (quarter_delay != bd_q));
    end

    // capture the host setting at each frame pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_act <= RATE_EIGHTH;
            cd_q     <= '0;
            bd_q     <= '0;
        end else if (frame_pulse) begin
            rate_act <= rate_t'(rate_sel);
            cd_q     <= chan_delay;
            bd_q     <= quarter_delay;
        end
    end

    // R6
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> ($stable(rate_act) && $stable(cd_q) && $stable(bd_q)));
endmodule

// File: rtl/skew_slot_decode.sv
// Delayed slot decoder.
// Subtracts the programmed delay from the frame position. It then splits the
// result into channel, bit and offset within the bit, and raises a strobe
// in the middle of each bit period.
// Assumes: CLK_LOG2 >= 2 so a quarter bit spans at least one cycle, and
// CH_LOG2 >= 3 so the slowest rate still has one channel.
module skew_slot_decode
    import skew_align_pkg::*;
#(
    parameter int CH_LOG2  = 8,
    parameter int CLK_LOG2 = 3,
    parameter int CHD_W    = 8,
    parameter int BD_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CH_LOG2+BYTE_LOG2+CLK_LOG2-1:0] pos_now,
    input  logic               run_now,
    input  rate_t              rate_now,
    input  logic [CHD_W-1:0]   cd_now,
    input  logic [BD_W-1:0]    bd_now,
    output logic               strobe,
    output logic [2:0]         bit_idx,
    output logic [CH_LOG2-1:0] chan_idx
);
    localparam int FW = CH_LOG2 + BYTE_LOG2 + CLK_LOG2;
    localparam int SW = $clog2(FW + 1);

    logic [SW-1:0] bit_log2;
    logic [FW-1:0] ch_mask, cd_eff, dly, dpos, bit_off, half, bit_num;

    // rate-dependent geometry and the delayed position
    always_comb begin
        bit_log2 = SW'(CLK_LOG2 + BYTE_LOG2) - SW'(rate_now);
        ch_mask  = (FW'(1) << (SW'(CH_LOG2 - BYTE_LOG2) + SW'(rate_now))) - FW'(1);
        cd_eff   = FW'(cd_now) & ch_mask;
        dly      = (cd_eff << (bit_log2 + SW'(BYTE_LOG2))) +
                   (FW'(bd_now) << (bit_log2 - SW'(QSTEP_LOG2)));
        dpos     = pos_now - dly;
        bit_off  = dpos & ((FW'(1) << bit_log2) - FW'(1));
        half     = FW'(1) << (bit_log2 - SW'(1));
        bit_num  = dpos >> bit_log2;
        bit_idx  = bit_num[2:0];
        chan_idx = CH_LOG2'(dpos >> (bit_log2 + SW'(BYTE_LOG2)));
        strobe   = run_now && (bit_off == half);
    end

    // R5
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/skew_byte_pack.sv
// Byte assembler.
// Shifts in one sample per strobe, MSB first. On the eighth bit of a channel
// it emits the byte and its channel number. A byte is emitted only if its
// first bit was sampled after the latest restart.
// Assumes: strobes arrive with bit indices 0..7 in order within a channel.
module skew_byte_pack #(
    parameter int CH_LOG2 = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [2:0]         bit_idx,
    input  logic [CH_LOG2-1:0] chan_idx,
    input  logic               ser_in,
    input  logic               restart,
    output logic               byte_valid,
    output logic [7:0]         byte_out,
    output logic [CH_LOG2-1:0] byte_chan
);
    logic [6:0] shreg;
    logic       armed;
    logic       emit;

    // emit only complete bytes sampled wholly under one setting
    always_comb emit = strobe && (bit_idx == 3'd7) && armed && !restart;

    // shift samples, track whether the byte was started cleanly, drive outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            armed      <= 1'b0;
            byte_valid <= 1'b0;
            byte_out   <= '0;
            byte_chan  <= '0;
        end else begin
            if (strobe) shreg <= {shreg[5:0], ser_in};
            if (strobe && bit_idx == 3'd0) armed <= 1'b1;
            else if (restart)              armed <= 1'b0;
            byte_valid <= emit;
            if (emit) begin
                byte_out  <= {shreg, ser_in};
                byte_chan <= chan_idx;
            end
        end
    end

    // R8
    valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
endmodule

// File: rtl/input_skew_aligner.sv
// Per-stream input skew aligner (top).
// Delays the sampling window of one serial stream by whole channels plus
// quarter-bit steps, measured from the frame pulse. It delivers channel
// bytes tagged with their channel numbers.
// Assumes: frame pulses are spaced exactly one frame length apart in
// steady state; BD_W <= 5 so the bit delay stays below eight bits.
module input_skew_aligner
    import skew_align_pkg::*;
#(
    parameter int CH_LOG2  = 8,
    parameter int CLK_LOG2 = 3,
    parameter int CHD_W    = 8,
    parameter int BD_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_pulse,
    input  logic               ser_in,
    input  logic [1:0]         rate_sel,
    input  logic [CHD_W-1:0]   chan_delay,
    input  logic [BD_W-1:0]    quarter_delay,
    output logic               byte_valid,
    output logic [7:0]         byte_out,
    output logic [CH_LOG2-1:0] byte_chan
);
    localparam int FW = CH_LOG2 + BYTE_LOG2 + CLK_LOG2;

    logic [FW-1:0]      pos_now;
    logic               run_now, run_seen, resync, changed, restart;
    rate_t              rate_now, rate_act;
    logic [CHD_W-1:0]   cd_now;
    logic [BD_W-1:0]    bd_now;
    logic               strobe;
    logic [2:0]         bit_idx;
    logic [CH_LOG2-1:0] chan_idx;

    skew_frame_timer #(.FW(FW)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .pos_now(pos_now), .run_now(run_now), .run_seen(run_seen),
        .resync(resync)
    );

    skew_cfg_hold #(.CHD_W(CHD_W), .BD_W(BD_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .rate_sel(rate_sel), .chan_delay(chan_delay),
        .quarter_delay(quarter_delay), .rate_now(rate_now),
        .cd_now(cd_now), .bd_now(bd_now), .rate_act(rate_act),
        .changed(changed)
    );

    // a changed setting or an off-grid pulse discards the straddling byte
    always_comb restart = changed | resync;

    skew_slot_decode #(.CH_LOG2(CH_LOG2), .CLK_LOG2(CLK_LOG2),
                       .CHD_W(CHD_W), .BD_W(BD_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .pos_now(pos_now), .run_now(run_now),
        .rate_now(rate_now), .cd_now(cd_now), .bd_now(bd_now),
        .strobe(strobe), .bit_idx(bit_idx), .chan_idx(chan_idx)
    );

    skew_byte_pack #(.CH_LOG2(CH_LOG2)) u_pack (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .bit_idx(bit_idx),
        .chan_idx(chan_idx), .ser_in(ser_in), .restart(restart),
        .byte_valid(byte_valid), .byte_out(byte_out), .byte_chan(byte_chan)
    );

    // R1
    quiet_before_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_seen |-> !byte_valid);

    // R8
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (int'(byte_chan) < (1 << (CH_LOG2 - BYTE_LOG2 + int'(rate_act)))));
endmodule

// File: tb/test_input_skew_aligner.sv
// Self-checking bench: sweeps every rate, channel delay (with wrap) and a
// set of quarter delays on a small geometry, with an arithmetic model.
module test_input_skew_aligner;
    localparam int CH_LOG2  = 3;
    localparam int CLK_LOG2 = 2;
    localparam int CHD_W    = 4;
    localparam int BD_W     = 5;
    localparam int F        = 1 << (CH_LOG2 + 3 + CLK_LOG2);
    localparam int LIMIT    = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_pulse = 1'b0;
    logic ser_in = 1'b0;
    logic [1:0] rate_sel = '0;
    logic [CHD_W-1:0] chan_delay = '0;
    logic [BD_W-1:0] quarter_delay = '0;
    logic byte_valid;
    logic [7:0] byte_out;
    logic [CH_LOG2-1:0] byte_chan;

    int checks = 0;
    int fails = 0;
    int ecnt = 0;
    int m_rate = 0, m_cd = 0, m_bd = 0, m_fpe = 0;
    int s_rate = 0, s_cd = 0, s_bd = 0;
    bit started = 1'b0;
    bit win_chk = 1'b0;
    int win_cnt = 0, win_n = 0;

    input_skew_aligner #(.CH_LOG2(CH_LOG2), .CLK_LOG2(CLK_LOG2),
                         .CHD_W(CHD_W), .BD_W(BD_W)) i_input_skew_aligner (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
        .rate_sel(rate_sel), .chan_delay(chan_delay),
        .quarter_delay(quarter_delay), .byte_valid(byte_valid),
        .byte_out(byte_out), .byte_chan(byte_chan)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        ecnt <= ecnt + 1;
        if (ecnt == LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", ecnt);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int wrapf(input int x);
        return ((x % F) + F) % F;
    endfunction

    function automatic int nch(input int r);
        return 1 << (CH_LOG2 - 3 + r);
    endfunction

    function automatic int dly(input int r, input int cd, input int bd);
        int bl;
        bl = CLK_LOG2 + 3 - r;
        return ((cd % nch(r)) << (bl + 3)) + (bd << (bl - 2));
    endfunction

    function automatic logic [7:0] pat(input int c);
        return 8'((c * 75 + 19) ^ 8'hA5);
    endfunction

    task automatic fail_line(input string tag, input string what, input int got, input int exp);
        fails = fails + 1;
        $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    endtask

    // one cycle: judge the outputs of the latest edge, then drive the next
    task automatic step(input bit fp_nxt, input int fidx);
        int n, bl, bc, d, p, c, expt, k;
        string tg;
        n = ecnt;
        if (!started) begin
            checks = checks + 1;
            if (byte_valid) fail_line("R1", "valid before frame", 1, 0);
        end else if (byte_valid) begin
            win_cnt = win_cnt + 1;
            bl = CLK_LOG2 + 3 - m_rate;
            bc = 1 << bl;
            d = dly(m_rate, m_cd, m_bd);
            p = wrapf(n - m_fpe - d);
            c = p >> (bl + 3);
            expt = c * 8 * bc + 7 * bc + bc / 2;
            if (s_rate != m_rate || s_cd != m_cd || s_bd != m_bd) tg = "R6";
            else if (m_cd >= nch(m_rate)) tg = "R4";
            else tg = "R2";
            checks = checks + 1;
            if (p != expt) fail_line(tg, "sample position", p, expt);
            checks = checks + 1;
            if (int'(byte_chan) != c) fail_line(tg, "channel", int'(byte_chan), c);
            checks = checks + 1;
            if (byte_out != pat(c)) fail_line("R3", "byte", int'(byte_out), int'(pat(c)));
        end
        if (fp_nxt) begin
            if (win_chk) begin
                checks = checks + 1;
                if (win_cnt != win_n) fail_line("R7", "bytes per frame", win_cnt, win_n);
            end
            m_rate = s_rate; m_cd = s_cd; m_bd = s_bd;
            m_fpe = n + 1;
            started = 1'b1;
            win_cnt = 0;
            win_chk = (fidx >= 1);
            win_n = nch(m_rate);
        end
        frame_pulse = fp_nxt;
        if (started) begin
            bl = CLK_LOG2 + 3 - m_rate;
            p = wrapf(n + 1 - m_fpe - dly(m_rate, m_cd, m_bd));
            c = p >> (bl + 3);
            k = (p >> bl) & 7;
            ser_in = pat(c)[7 - k];
        end else begin
            ser_in = n[0] ^ n[2];
        end
        @(negedge clk);
    endtask

    // R6: the new setting is applied half a frame before the pulse
    task automatic run_cfg(input int r, input int cd, input int bd);
        rate_sel = 2'(r); chan_delay = CHD_W'(cd); quarter_delay = BD_W'(bd);
        s_rate = r; s_cd = cd; s_bd = bd;
        repeat (F / 2) step(1'b0, 0);
        for (int f = 0; f < 3; f++) begin
            step(1'b1, f);
            repeat ((f == 2) ? (F / 2 - 1) : (F - 1)) step(1'b0, 0);
        end
    endtask

    initial begin
        @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            // R1: reset state
            checks = checks + 1;
            if (byte_valid !== 1'b0) fail_line("R1", "valid in reset", int'(byte_valid), 0);
        end
        rst_n = 1'b1;
        repeat (20) step(1'b0, 0);
        step(1'b1, 0);
        repeat (F / 2 - 1) step(1'b0, 0);
        // R5: every rate code; R4: channel delays beyond the wrap
        for (int r = 0; r < 4; r++) begin
            for (int ci = 0; ci <= nch(r) + 1; ci++) begin
                for (int bi = 0; bi < 4; bi++) begin
                    run_cfg(r, (ci <= nch(r)) ? ci : 15,
                            (bi == 0) ? 0 : (bi == 1) ? 1 : (bi == 2) ? 5 : 31);
                end
            end
        end
        repeat (F / 2) step(1'b0, 0);
        step(1'b1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule